// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit produces the packed 16-bit status and control flag word that sits beside an integer ALU. Each cycle it takes two operands, an operation code and a width select. When the flag write enable is high it recomputes the arithmetic status flags from its own add, subtract or bitwise evaluation of the operands. It works at either byte or word width, and at byte width the upper operand bits have no effect.

The same register holds three control bits: step trap, interrupt enable and string direction. Only dedicated set and clear command vectors change them. Add-with-carry and subtract-with-borrow take their carry or borrow input from the carry bit that is already stored, so multi-word arithmetic can be chained one operation per cycle. The flag word is registered, so every update shows on the output one clock after the edge that accepts it.

Top module: `alu_flag_unit`

## Requirements
- R1: After an active-low reset the flag word reads 0x0002. Field positions are carry=0, parity=2, aux=4, zero=6, sign=7, trap=8, interrupt-enable=9, direction=10, overflow=11. Bit 1 always reads 1 and bits 3, 5 and 12 to 15 always read 0.
- R2: The operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow. The carry bit is the carry out of the active-width MSB for additions. For subtractions it is a borrow: it is set when the unsigned minuend is less than subtrahend plus borrow-in. Codes 1 and 3 use the stored carry bit as carry-in or borrow-in.
- R3: Width select 1 means 16-bit and 0 means 8-bit. The zero bit is set when the active-width result is all zeros, and the sign bit equals the active-width result MSB. Operand bits above bit 7 do not affect any flag in 8-bit mode.
- R4: The parity bit is set when result bits 7:0 contain an even number of ones, in either width.
- R5: The aux bit reports a carry out of bit 3 for additions, or a borrow into bit 3 from bit 4 for subtractions.
- R6: The overflow bit is set when the carry (or borrow) into the active-width MSB differs from the carry (or borrow) out of it.
- R7: Set and clear command vectors use the bit order [0] trap, [1] interrupt enable, [2] direction. A control bit changes only in the cycle after a set or clear command for it, and never through the write enable.
- R8: Codes 4 (AND), 5 (OR) and 6 (XOR) clear carry and overflow, update zero, sign and parity from the bitwise result, and leave aux unchanged.
- R9: With the write enable low, or with code 7, none of the six arithmetic flags change.
- R10: If the set and the clear command hit the same control bit in one cycle, the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand (minuend for subtraction) |
| opB | input | 16 | Second operand (subtrahend for subtraction) |
| aluOp | input | 3 | Operation code (see R2, R8, R9) |
| wideSel | input | 1 | 1 = 16-bit, 0 = 8-bit |
| flagWe | input | 1 | Update arithmetic flags this cycle |
| ctrlSet | input | 3 | Set commands for trap, interrupt enable, direction |
| ctrlClr | input | 3 | Clear commands, same order; clear has priority |
| flagWord | output | 16 | Registered packed flag word |

## Verification
All state lives in the one flag register, so any corruption shows on flagWord one clock after the edge that causes it. The exception is a wrong stored carry, which may stay hidden until an add-with-carry or subtract-with-borrow consumes it. That operation then shows a wrong carry, zero or parity bit in the very next cycle. The bench therefore chains carry-consuming operations in its random phase, so a stale or wrongly captured carry surfaces within a few cycles. A swapped field position appears at once, because every bit is compared with a behavioural model on every clock.

// File: rtl/flag_pkg.sv
package flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_NONE = 3'd7
  } aluOpE;

  localparam int CTRL_N = 3;

  localparam int CF_POS = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  // Strobes from control to datapath
  typedef struct packed {
    logic              arithEn;
    logic              logicEn;
    logic              subtract;
    logic              chainCarry;
    logic              wideMode;
    logic [1:0]        logicSel;
    logic [CTRL_N-1:0] setMask;
    logic [CTRL_N-1:0] clrMask;
  } flagStrobeT;

endpackage

// File: rtl/flag_arith.sv
module flag_arith #(
  parameter int W = 16,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carryOut,
  output logic         auxOut,
  output logic         ovfOut
);
  logic [W-1:0] bEff;
  logic         cEff;
  logic [W:0]   ext;
  logic         carryIntoMsb;

  always_comb begin
    bEff = sub ? ~b : b;
    cEff = sub ? ~cin : cin;
    ext = {1'b0, a} + {1'b0, bEff} + {{W{1'b0}}, cEff};
    res = ext[W-1:0];
    // a borrow is the inverse of the carry of the complemented sum
    carryOut = ext[W] ^ sub;
    auxOut = a[NIB] ^ bEff[NIB] ^ res[NIB] ^ sub;
    carryIntoMsb = a[W-1] ^ bEff[W-1] ^ res[W-1];
    ovfOut = carryIntoMsb ^ ext[W];
  end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        aluOp,
  input  logic              wideSel,
  input  logic              flagWe,
  input  logic [CTRL_N-1:0] ctrlSet,
  input  logic [CTRL_N-1:0] ctrlClr,
  output flagStrobeT        strobe
);
  aluOpE opCode;

  always_comb begin
    opCode = aluOpE'(aluOp);
    strobe = '0;
    strobe.wideMode = wideSel;
    strobe.setMask = ctrlSet;
    strobe.clrMask = ctrlClr;
    unique case (opCode)
      OP_ADD: strobe.arithEn = flagWe;
      OP_ADC: begin strobe.arithEn = flagWe; strobe.chainCarry = 1'b1; end
      OP_SUB: begin strobe.arithEn = flagWe; strobe.subtract = 1'b1; end
      OP_SBB: begin
        strobe.arithEn = flagWe;
        strobe.subtract = 1'b1;
        strobe.chainCarry = 1'b1;
      end
      OP_AND: begin strobe.logicEn = flagWe; strobe.logicSel = 2'd0; end
      OP_OR:  begin strobe.logicEn = flagWe; strobe.logicSel = 2'd1; end
      OP_XOR: begin strobe.logicEn = flagWe; strobe.logicSel = 2'd2; end
      default: ;
    endcase
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.arithEn, strobe.logicEn})); // R9
  AST_NO_WE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |-> !(strobe.arithEn || strobe.logicEn)); // R9
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  flagStrobeT        strobe,
  output logic [WORD_W-1:0] flagWord
);
  localparam int N_WIDTHS = 2;
  localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << ONE_POS;
  localparam logic [WORD_W-1:0] LIVE_MASK =
    (WORD_W'(1) << CF_POS) | (WORD_W'(1) << ONE_POS) | (WORD_W'(1) << PF_POS) |
    (WORD_W'(1) << AF_POS) | (WORD_W'(1) << ZF_POS) | (WORD_W'(1) << SF_POS) |
    (WORD_W'(1) << TF_POS) | (WORD_W'(1) << IF_POS) | (WORD_W'(1) << DF_POS) |
    (WORD_W'(1) << OF_POS);
  localparam int CTRL_POS [CTRL_N] = '{TF_POS, IF_POS, DF_POS};

  logic [WORD_W-1:0] flagQ;
  logic [WORD_W-1:0] flagD;
  logic [WORD_W-1:0] resArr [N_WIDTHS];
  logic [N_WIDTHS-1:0] carryArr, auxArr, ovfArr;
  logic carryIn;

  assign carryIn = flagQ[CF_POS] & strobe.chainCarry;

  for (genvar gi = 0; gi < N_WIDTHS; gi++) begin : g_width
    localparam int W = (gi == 0) ? BYTE_W : WORD_W;
    logic [W-1:0] r;
    logic co, ao, oo;
    flag_arith #(.W(W)) u_arith (
      .a(opA[W-1:0]), .b(opB[W-1:0]), .cin(carryIn), .sub(strobe.subtract),
      .res(r), .carryOut(co), .auxOut(ao), .ovfOut(oo)
    );
    assign resArr[gi] = WORD_W'(r);
    assign carryArr[gi] = co;
    assign auxArr[gi] = ao;
    assign ovfArr[gi] = oo;
  end

  logic [WORD_W-1:0] logicWord;
  logic [WORD_W-1:0] widthMask;
  logic [WORD_W-1:0] activeRes;
  logic widthIdx;
  logic resMsb;

  always_comb begin
    unique case (strobe.logicSel)
      2'd0: logicWord = opA & opB;
      2'd1: logicWord = opA | opB;
      default: logicWord = opA ^ opB;
    endcase
    widthIdx = strobe.wideMode;
    widthMask = strobe.wideMode ? '1 : WORD_W'((1 << BYTE_W) - 1);
    activeRes = (strobe.logicEn ? logicWord : resArr[widthIdx]) & widthMask;
    resMsb = strobe.wideMode ? activeRes[WORD_W-1] : activeRes[BYTE_W-1];
  end

  always_comb begin
    flagD = flagQ;
    if (strobe.arithEn || strobe.logicEn) begin
      flagD[ZF_POS] = (activeRes == '0);
      flagD[SF_POS] = resMsb;
      flagD[PF_POS] = ~(^activeRes[BYTE_W-1:0]);
    end
    if (strobe.arithEn) begin
      flagD[CF_POS] = carryArr[widthIdx];
      flagD[AF_POS] = auxArr[widthIdx];
      flagD[OF_POS] = ovfArr[widthIdx];
    end else if (strobe.logicEn) begin
      flagD[CF_POS] = 1'b0;
      flagD[OF_POS] = 1'b0;
    end
    for (int ci = 0; ci < CTRL_N; ci++) begin
      if (strobe.clrMask[ci]) flagD[CTRL_POS[ci]] = 1'b0;
      else if (strobe.setMask[ci]) flagD[CTRL_POS[ci]] = 1'b1;
    end
    flagD = (flagD & LIVE_MASK) | RESET_WORD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= RESET_WORD;
    else flagQ <= flagD;
  end

  assign flagWord = flagQ;

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[ONE_POS] && ((flagQ & ~LIVE_MASK) == '0)); // R1
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[ZF_POS] |-> !flagQ[SF_POS]); // R3
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.logicEn |=> (!flagQ[CF_POS] && !flagQ[OF_POS])); // R8
  AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk) disable iff (!rstN)
    strobe.logicEn |=> $stable(flagQ[AF_POS])); // R8
  AST_ARITH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.arithEn || strobe.logicEn) |=> $stable({flagQ[OF_POS], flagQ[SF_POS],
      flagQ[ZF_POS], flagQ[AF_POS], flagQ[PF_POS], flagQ[CF_POS]})); // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setMask == '0 && strobe.clrMask == '0) |=>
      $stable({flagQ[DF_POS], flagQ[IF_POS], flagQ[TF_POS]})); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrMask[0] |=> !flagQ[TF_POS]); // R10
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [2:0]        aluOp,
  input  logic              wideSel,
  input  logic              flagWe,
  input  logic [2:0]        ctrlSet,
  input  logic [2:0]        ctrlClr,
  output logic [WORD_W-1:0] flagWord
);
  flagStrobeT strobe;

  flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aluOp(aluOp), .wideSel(wideSel), .flagWe(flagWe),
    .ctrlSet(ctrlSet), .ctrlClr(ctrlClr), .strobe(strobe)
  );

  flag_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .strobe(strobe),
    .flagWord(flagWord)
  );
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [2:0] aluOp = 3'd7;
  logic wideSel = 1'b0, flagWe = 1'b0;
  logic [2:0] ctrlSet = '0, ctrlClr = '0;
  logic [15:0] flagWord;
  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  bit mCf, mPf, mAf, mZf, mSf, mOf, mTf, mIf, mDf;

  always #5 clk = ~clk;

  alu_flag_unit dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .aluOp(aluOp), .wideSel(wideSel),
    .flagWe(flagWe), .ctrlSet(ctrlSet), .ctrlClr(ctrlClr), .flagWord(flagWord)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 carry", int'(flagWord[0]), int'(mCf));
    chk("R4 parity", int'(flagWord[2]), int'(mPf));
    chk("R5 aux", int'(flagWord[4]), int'(mAf));
    chk("R3 zero", int'(flagWord[6]), int'(mZf));
    chk("R3 sign", int'(flagWord[7]), int'(mSf));
    chk("R6 overflow", int'(flagWord[11]), int'(mOf));
    chk("R7 trap", int'(flagWord[8]), int'(mTf));
    chk("R7 intr", int'(flagWord[9]), int'(mIf));
    chk("R7 dir", int'(flagWord[10]), int'(mDf));
    chk("R1 fixed", int'(flagWord & 16'hF02A), 32'h0002);
  endtask

  task automatic modelStep();
    int w, full, half, av, bv, c, r, sa, sb, sr, ones;
    bit nc [3];
    w = wideSel ? 16 : 8;
    full = 1 << w;
    half = 1 << (w - 1);
    av = int'(opA) & (full - 1);
    bv = int'(opB) & (full - 1);
    c = (aluOp == 3'd1 || aluOp == 3'd3) ? int'(mCf) : 0;
    sa = (av >= half) ? av - full : av;
    sb = (bv >= half) ? bv - full : bv;
    if (flagWe && aluOp != 3'd7) begin
      if (aluOp <= 3'd1) begin
        r = av + bv + c;
        mCf = r >= full;
        mAf = ((av & 15) + (bv & 15) + c) > 15;
        sr = sa + sb + c;
        mOf = (sr >= half) || (sr < -half);
        r = r & (full - 1);
      end else if (aluOp <= 3'd3) begin
        mCf = av < bv + c;
        mAf = (av & 15) < (bv & 15) + c;
        sr = sa - sb - c;
        mOf = (sr >= half) || (sr < -half);
        r = (av - bv - c) & (full - 1);
      end else begin
        r = (aluOp == 3'd4) ? (av & bv) : (aluOp == 3'd5) ? (av | bv) : (av ^ bv);
        mCf = 0;
        mOf = 0;
      end
      mZf = (r == 0);
      mSf = ((r >> (w - 1)) & 1) == 1;
      ones = 0;
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      mPf = (ones % 2) == 0;
    end
    nc[0] = ctrlClr[0] ? 1'b0 : (ctrlSet[0] ? 1'b1 : mTf);
    nc[1] = ctrlClr[1] ? 1'b0 : (ctrlSet[1] ? 1'b1 : mIf);
    nc[2] = ctrlClr[2] ? 1'b0 : (ctrlSet[2] ? 1'b1 : mDf);
    mTf = nc[0];
    mIf = nc[1];
    mDf = nc[2];
  endtask

  // called at a negedge; drives, clocks the model, compares at next negedge
  task automatic cyc(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                     input logic wd, input logic we, input logic [2:0] st,
                     input logic [2:0] cl);
    opA = a; opB = b; aluOp = op; wideSel = wd; flagWe = we; ctrlSet = st; ctrlClr = cl;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset word 0x0002
    chk("R1 reset", int'(flagWord), 32'h0002);
    rstN = 1'b1;
    // R2 R3 R5 R6: byte 0x7F + 0x01 -> sign, aux, overflow
    cyc(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b1, 3'b000, 3'b000);
    // R2 R3 R4: byte 0xFF + 0x01 -> carry, zero, parity
    cyc(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b1, 3'b000, 3'b000);
    // R2: add with carry uses stored carry
    cyc(16'h0010, 16'h0020, 3'd1, 1'b0, 1'b1, 3'b000, 3'b000);
    // R3: byte mode ignores upper operand bits
    cyc(16'hAB00, 16'h1200, 3'd0, 1'b0, 1'b1, 3'b000, 3'b000);
    // R6: word 0x7FFF + 1 overflow
    cyc(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b1, 3'b000, 3'b000);
    // R2 R5: subtract 0 - 1 byte borrow
    cyc(16'h0000, 16'h0001, 3'd2, 1'b0, 1'b1, 3'b000, 3'b000);
    // R2: subtract with borrow, stored borrow consumed
    cyc(16'h0005, 16'h0005, 3'd3, 1'b1, 1'b1, 3'b000, 3'b000);
    // R6: word 0x8000 - 1 overflow
    cyc(16'h8000, 16'h0001, 3'd2, 1'b1, 1'b1, 3'b000, 3'b000);
    // R8: logic ops clear carry/overflow, keep aux
    cyc(16'h0F0F, 16'h00FF, 3'd4, 1'b1, 1'b1, 3'b000, 3'b000);
    cyc(16'h8000, 16'h0001, 3'd5, 1'b1, 1'b1, 3'b000, 3'b000);
    cyc(16'h00AA, 16'h00AA, 3'd6, 1'b0, 1'b1, 3'b000, 3'b000);
    // R9: write enable low and code 7 leave flags unchanged
    cyc(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b0, 3'b000, 3'b000);
    cyc(16'h00FF, 16'h0001, 3'd7, 1'b0, 1'b1, 3'b000, 3'b000);
    // R7: set and clear each control bit, not touched by write enable
    cyc(16'h0000, 16'h0000, 3'd0, 1'b1, 1'b1, 3'b111, 3'b000);
    cyc(16'h0000, 16'h0000, 3'd0, 1'b1, 1'b1, 3'b000, 3'b010);
    cyc(16'h0000, 16'h0000, 3'd7, 1'b1, 1'b0, 3'b000, 3'b000);
    // R10: clear beats set on the same bit
    cyc(16'h0000, 16'h0000, 3'd7, 1'b1, 1'b0, 3'b101, 3'b001);
    cyc(16'h0000, 16'h0000, 3'd7, 1'b1, 1'b0, 3'b011, 3'b011);
    // random phase, chained carries and mixed widths
    for (int i = 0; i < 400; i++) begin
      cyc(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom),
          ($urandom % 4) != 0, 3'($urandom % 8 == 0 ? $urandom : 0),
          3'($urandom % 8 == 0 ? $urandom : 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule